// File: doc/BRIEF.md
# Parallel March Self-Test with Spare-Row Repair

This block runs a built-in self-test on several single-port synchronous RAMs of identical shape, all at once. A one-cycle `start` pulse hands every RAM port to an internal sequencer. The sequencer applies a six-element march sequence with solid backgrounds, all zeros and all ones. Every read is compared against its expected value in the cycle after its address is issued, which matches the RAM's one-cycle read latency.

Each memory has its own analyzer. The analyzer logs each distinct failing row into one of `NSPARE` spare slots and decides whether the spares are enough to fix the memory. When the run ends, the functional port of every repairable memory sends accesses aimed at a logged row to that row's spare. Spare slot k sits at physical row `DEPTH + k`. The logged rows are also presented as repair entries, one per slot, so that logic outside the block can make the repair permanent.

Top module: `mbist_repair`

## Requirements
- R1: A `start` pulse accepted while idle or finished raises `test_mode` at the next clock edge. `test_mode` stays high for exactly 10*DEPTH+1 cycles, and `done` rises at the same edge where `test_mode` falls.
- R2: While `test_mode` is high, the functional inputs have no effect on the RAM ports. Address, data and write enable come only from the sequencer, and no test address reaches the spare rows (address >= DEPTH).
- R3: One operation is issued per cycle, in this order. First, ascending write 0. Then ascending read 0 / write 1, and ascending read 1 / write 0. Then descending read 0 / write 1, and descending read 1 / write 0. Last, ascending read 0. A written 0 drives all data bits low and a written 1 drives them all high. Reads hold write enable low.
- R4: Read data is compared in the cycle after the read address is issued. A mismatch sets `mem_fail` only for the memory that returned it.
- R5: A failing row that is detected more than once occupies only one repair entry.
- R6: Distinct failing rows fill repair entries 0, 1, … in order of first detection. A memory with at most NSPARE distinct failing rows reports `mem_repairable` = 1.
- R7: A memory with more distinct failing rows than NSPARE reports `mem_fail` = 1 and `mem_repairable` = 0.
- R8: After `done`, a functional address in a repairable memory that matches repair entry k drives RAM address DEPTH+k. Any other address passes through unchanged. An unrepairable memory is never remapped.
- R9: Accepting a new `start` drops `done` and clears all fail flags and repair entries.
- R10: After reset, `done`, `test_mode`, `mem_fail` and every repair-entry valid bit are 0.
- R11: A `start` pulse that arrives while a test is running is ignored, and the run still finishes at the time stated in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a self-test run |
| func_addr | input | NMEM*AW | Functional row address per memory |
| func_wdata | input | NMEM*W | Functional write data per memory |
| func_we | input | NMEM | Functional write enable per memory |
| ram_addr | output | NMEM*PAW | Physical RAM address per memory (spares included) |
| ram_wdata | output | NMEM*W | RAM write data per memory |
| ram_we | output | NMEM | RAM write enable per memory |
| ram_rdata | input | NMEM*W | RAM read data, valid one cycle after the address |
| test_mode | output | 1 | Sequencer owns the RAM ports |
| done | output | 1 | Last run finished; flags and entries are final |
| mem_fail | output | NMEM | Memory showed at least one mismatch |
| mem_repairable | output | NMEM | Failing rows fit in the spares |
| rep_valid | output | NMEM*NSPARE | Repair entry occupied, memory-major |
| rep_row | output | NMEM*NSPARE*AW | Logged failing row per entry |

## Verification
The bench samples on the falling edge. `test_mode` is checked at the first falling edge after the edge that latched `start`. From there, each of the 10*DEPTH sequencer operations is due one falling edge after the previous one, and the bench compares every operation against a schedule that it rebuilds on its own. One drain cycle follows, with `test_mode` still high and no write. `done` and the final flags are checked one edge after that, because the last comparison is logged at the same edge where `done` rises. The remap is combinational, so each remap check sets the functional address and samples one nanosecond later, inside the same cycle.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DRAIN,
        ST_DONE
    } mb_state_e;

    localparam logic [2:0] LAST_ELEM = 3'd5;

    typedef struct packed {
        logic is_wr;
        logic val;
    } mb_op_t;

    // elements 3 and 4 walk the address space downward
    function automatic logic elem_down(input logic [2:0] e);
        return (e == 3'd3) || (e == 3'd4);
    endfunction

    // elements 1..4 carry a read followed by a write
    function automatic logic elem_two(input logic [2:0] e);
        return (e >= 3'd1) && (e <= 3'd4);
    endfunction

    function automatic mb_op_t elem_op(input logic [2:0] e, input logic opi);
        mb_op_t o;
        case (e)
            3'd0:        o = '{is_wr: 1'b1, val: 1'b0};
            3'd1, 3'd3:  o = opi ? '{is_wr: 1'b1, val: 1'b1} : '{is_wr: 1'b0, val: 1'b0};
            3'd2, 3'd4:  o = opi ? '{is_wr: 1'b1, val: 1'b0} : '{is_wr: 1'b0, val: 1'b1};
            default:     o = '{is_wr: 1'b0, val: 1'b0};
        endcase
        return o;
    endfunction

endpackage

// File: rtl/mbist_seq.sv
module mbist_seq
    import mbist_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          clr,
    output logic [AW-1:0] seq_addr,
    output logic          seq_we,
    output logic          seq_val,
    output logic          cmp_vld,
    output logic [AW-1:0] cmp_addr,
    output logic          cmp_val
);

    mb_state_e     state;
    logic [2:0]    elem;
    logic [AW-1:0] addr;
    logic          opi;
    mb_op_t        op;
    logic          last_op;
    logic          last_addr;
    logic [2:0]    nxt_elem;

    always_comb begin
        op        = elem_op(elem, opi);
        last_op   = elem_two(elem) ? opi : 1'b1;
        last_addr = elem_down(elem) ? (addr == '0) : (addr == AW'(DEPTH - 1));
        nxt_elem  = elem + 3'd1;
        seq_we    = (state == ST_RUN) && op.is_wr;
        seq_val   = op.val;
        seq_addr  = addr;
        busy      = (state == ST_RUN) || (state == ST_DRAIN);
        done      = (state == ST_DONE);
        clr       = ((state == ST_IDLE) || (state == ST_DONE)) && start;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            elem     <= '0;
            addr     <= '0;
            opi      <= 1'b0;
            cmp_vld  <= 1'b0;
            cmp_addr <= '0;
            cmp_val  <= 1'b0;
        end else begin
            cmp_vld  <= (state == ST_RUN) && !op.is_wr;
            cmp_addr <= addr;
            cmp_val  <= op.val;
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        state <= ST_RUN;
                        elem  <= '0;
                        addr  <= '0;
                        opi   <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (!last_op) begin
                        opi <= 1'b1;
                    end else begin
                        opi <= 1'b0;
                        if (!last_addr) begin
                            addr <= elem_down(elem) ? addr - 1'b1 : addr + 1'b1;
                        end else if (elem == LAST_ELEM) begin
                            state <= ST_DRAIN;
                        end else begin
                            elem <= nxt_elem;
                            addr <= elem_down(nxt_elem) ? AW'(DEPTH - 1) : '0;
                        end
                    end
                end
                default: state <= ST_DONE;
            endcase
        end
    end

    // march elements are visited strictly in sequence
    assert_elem_order_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && $past(state) == ST_RUN && elem != $past(elem))
            |-> elem == 3'($past(elem) + 3'd1))
        else $error("march element skipped");

endmodule

// File: rtl/mbist_rowlog.sv
module mbist_rowlog #(
    parameter int W      = 8,
    parameter int AW     = 4,
    parameter int NSPARE = 2,
    localparam int CW    = $clog2(NSPARE + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 cmp_vld,
    input  logic [AW-1:0]        cmp_addr,
    input  logic                 cmp_val,
    input  logic [W-1:0]         rdata,
    output logic                 fail,
    output logic                 ovf,
    output logic [NSPARE-1:0]    ent_vld,
    output logic [NSPARE*AW-1:0] ent_row
);

    logic [AW-1:0] row_q [NSPARE];
    logic [CW-1:0] cnt;
    logic          mism;
    logic          hit;

    always_comb begin
        mism = cmp_vld && (rdata != {W{cmp_val}});
        hit  = 1'b0;
        for (int k = 0; k < NSPARE; k++)
            if (ent_vld[k] && row_q[k] == cmp_addr) hit = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            fail    <= 1'b0;
            ovf     <= 1'b0;
            cnt     <= '0;
            ent_vld <= '0;
            for (int k = 0; k < NSPARE; k++) row_q[k] <= '0;
        end else if (mism) begin
            fail <= 1'b1;
            if (!hit) begin
                if (cnt < CW'(NSPARE)) begin
                    for (int k = 0; k < NSPARE; k++) begin
                        if (CW'(k) == cnt) begin
                            ent_vld[k] <= 1'b1;
                            row_q[k]   <= cmp_addr;
                        end
                    end
                    cnt <= cnt + 1'b1;
                end else begin
                    ovf <= 1'b1;
                end
            end
        end
    end

    for (genvar k = 0; k < NSPARE; k++) begin : g_flat
        assign ent_row[k*AW +: AW] = row_q[k];
    end

    always_ff @(posedge clk) begin
        if (!rst) begin
            for (int i = 0; i < NSPARE; i++)
                for (int j = i + 1; j < NSPARE; j++)
                    assert_no_dup_R5: assert (!(ent_vld[i] && ent_vld[j] && row_q[i] == row_q[j]))
                        else $error("row logged twice");
        end
    end

    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(NSPARE))
        else $error("spare count overran");

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clr) |=> ovf)
        else $error("overflow lost");

endmodule

// File: rtl/mbist_remap.sv
module mbist_remap #(
    parameter int DEPTH  = 16,
    parameter int NSPARE = 2,
    parameter int AW     = 4,
    parameter int PAW    = 5
) (
    input  logic                 en,
    input  logic [AW-1:0]        fa,
    input  logic [NSPARE-1:0]    ent_vld,
    input  logic [NSPARE*AW-1:0] ent_row,
    output logic [PAW-1:0]       pa
);

    always_comb begin
        pa = PAW'(fa);
        for (int k = 0; k < NSPARE; k++)
            if (en && ent_vld[k] && ent_row[k*AW +: AW] == fa)
                pa = PAW'(DEPTH + k);
    end

endmodule

// File: rtl/mbist_repair.sv
module mbist_repair #(
    parameter int NMEM   = 2,
    parameter int DEPTH  = 16,
    parameter int W      = 8,
    parameter int NSPARE = 2,
    localparam int AW    = $clog2(DEPTH),
    localparam int PAW   = $clog2(DEPTH + NSPARE)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [NMEM*AW-1:0]        func_addr,
    input  logic [NMEM*W-1:0]         func_wdata,
    input  logic [NMEM-1:0]           func_we,
    output logic [NMEM*PAW-1:0]       ram_addr,
    output logic [NMEM*W-1:0]         ram_wdata,
    output logic [NMEM-1:0]           ram_we,
    input  logic [NMEM*W-1:0]         ram_rdata,
    output logic                      test_mode,
    output logic                      done,
    output logic [NMEM-1:0]           mem_fail,
    output logic [NMEM-1:0]           mem_repairable,
    output logic [NMEM*NSPARE-1:0]    rep_valid,
    output logic [NMEM*NSPARE*AW-1:0] rep_row
);

    logic          busy;
    logic          clr;
    logic [AW-1:0] seq_addr;
    logic          seq_we;
    logic          seq_val;
    logic          cmp_vld;
    logic [AW-1:0] cmp_addr;
    logic          cmp_val;

    mbist_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
        .clk(clk), .rst(rst), .start(start),
        .busy(busy), .done(done), .clr(clr),
        .seq_addr(seq_addr), .seq_we(seq_we), .seq_val(seq_val),
        .cmp_vld(cmp_vld), .cmp_addr(cmp_addr), .cmp_val(cmp_val)
    );

    assign test_mode = busy;

    for (genvar m = 0; m < NMEM; m++) begin : g_mem
        logic                 fail;
        logic                 ovf;
        logic [PAW-1:0]       fpa;

        mbist_rowlog #(.W(W), .AW(AW), .NSPARE(NSPARE)) u_log (
            .clk(clk), .rst(rst), .clr(clr),
            .cmp_vld(cmp_vld), .cmp_addr(cmp_addr), .cmp_val(cmp_val),
            .rdata(ram_rdata[m*W +: W]),
            .fail(fail), .ovf(ovf),
            .ent_vld(rep_valid[m*NSPARE +: NSPARE]),
            .ent_row(rep_row[m*NSPARE*AW +: NSPARE*AW])
        );

        mbist_remap #(.DEPTH(DEPTH), .NSPARE(NSPARE), .AW(AW), .PAW(PAW)) u_map (
            .en(done && !ovf),
            .fa(func_addr[m*AW +: AW]),
            .ent_vld(rep_valid[m*NSPARE +: NSPARE]),
            .ent_row(rep_row[m*NSPARE*AW +: NSPARE*AW]),
            .pa(fpa)
        );

        assign ram_addr[m*PAW +: PAW] = busy ? PAW'(seq_addr) : fpa;
        assign ram_wdata[m*W +: W]    = busy ? {W{seq_val}} : func_wdata[m*W +: W];
        assign ram_we[m]              = busy ? seq_we : func_we[m];
        assign mem_fail[m]            = done && fail;
        assign mem_repairable[m]      = done && !ovf;

        assert_test_addr_R2: assert property (@(posedge clk) disable iff (rst)
            test_mode |-> ram_addr[m*PAW +: PAW] < PAW'(DEPTH))
            else $error("test touched a spare row");
    end

    assert_done_idle_R1: assert property (@(posedge clk) disable iff (rst)
        done |-> !test_mode)
        else $error("done while testing");

endmodule

// File: tb/mbist_repair_tb.sv
`timescale 1ns/1ps
module mbist_repair_tb;
    localparam int NMEM = 2, D = 16, W = 8, NS = 2;
    localparam int AW = 4, PAW = 5;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [NMEM*AW-1:0]    func_addr = '0;
    logic [NMEM*W-1:0]     func_wdata = '0;
    logic [NMEM-1:0]       func_we = '0;
    logic [NMEM*PAW-1:0]   ram_addr;
    logic [NMEM*W-1:0]     ram_wdata;
    logic [NMEM-1:0]       ram_we;
    logic [NMEM*W-1:0]     ram_rdata;
    logic                  test_mode, done;
    logic [NMEM-1:0]       mem_fail, mem_repairable;
    logic [NMEM*NS-1:0]    rep_valid;
    logic [NMEM*NS*AW-1:0] rep_row;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    logic [W-1:0] mem   [NMEM][D+NS];
    logic [W-1:0] stuck [NMEM][D+NS];

    always #2.5 clk = ~clk;

    mbist_repair #(.NMEM(NMEM), .DEPTH(D), .W(W), .NSPARE(NS)) u_dut (
        .clk(clk), .rst(rst), .start(start),
        .func_addr(func_addr), .func_wdata(func_wdata), .func_we(func_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
        .ram_rdata(ram_rdata), .test_mode(test_mode), .done(done),
        .mem_fail(mem_fail), .mem_repairable(mem_repairable),
        .rep_valid(rep_valid), .rep_row(rep_row)
    );

    always @(posedge clk) begin
        for (int m = 0; m < NMEM; m++) begin
            if (ram_we[m]) mem[m][ram_addr[m*PAW +: PAW]] <= ram_wdata[m*W +: W];
            ram_rdata[m*W +: W] <= mem[m][ram_addr[m*PAW +: PAW]] | stuck[m][ram_addr[m*PAW +: PAW]];
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_faults();
        for (int m = 0; m < NMEM; m++)
            for (int r = 0; r < D + NS; r++) stuck[m][r] = '0;
    endtask

    // runs one full march, checking every issued operation against the schedule
    task automatic run_march(input bit poke);
        int bad = 0;
        int step = 0;
        @(negedge clk);
        start = 1'b1;
        func_we = '1;
        func_wdata = {NMEM{8'hA5}};
        @(negedge clk);
        start = 1'b0;
        chk(test_mode && !done, "R9", "test_mode/done after start", {test_mode, done}, 2'b10);
        for (int e = 0; e < 6; e++) begin
            for (int a = 0; a < D; a++) begin
                for (int o = 0; o < ((e >= 1 && e <= 4) ? 2 : 1); o++) begin
                    int ad = (e == 3 || e == 4) ? D - 1 - a : a;
                    bit wr = (e == 0) || (o == 1);
                    bit v  = (e == 0) ? 1'b0 : (e == 1 || e == 3) ? 1'b1 : 1'b0;
                    for (int m = 0; m < NMEM; m++) begin
                        if (ram_we[m] !== wr || ram_addr[m*PAW +: PAW] !== PAW'(ad)) bad++;
                        if (wr && ram_wdata[m*W +: W] !== {W{v}}) bad++;
                    end
                    start = poke && (step == 20);
                    step++;
                    @(negedge clk);
                end
            end
        end
        start = 1'b0;
        chk(bad == 0, "R3", "op stream mismatches (R2 func ignored)", bad, 0);
        chk(test_mode && ram_we == '0 && !done, "R1", "drain cycle", {test_mode, ram_we, done}, 4'b1000);
        @(negedge clk);
        chk(done && !test_mode, "R1", "done at 10*D+1", {done, test_mode}, 2'b10);
        func_we = '0;
    endtask

    task automatic chk_map(input int m, input int fa, input int exp, input string req);
        func_addr[m*AW +: AW] = AW'(fa);
        #1;
        chk(ram_addr[m*PAW +: PAW] == PAW'(exp), req, "remapped address", ram_addr[m*PAW +: PAW], exp);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(!done && !test_mode && mem_fail == '0 && rep_valid == '0, "R10", "reset state",
            {done, test_mode, mem_fail, rep_valid}, 0);
    endtask

    task automatic t_clean();
        clear_faults();
        run_march(1'b1);
        chk(mem_fail == '0 && mem_repairable == '1, "R11", "clean run with stray start",
            {mem_fail, mem_repairable}, 4'b0011);
    endtask

    task automatic t_single();
        clear_faults();
        stuck[0][5] = 8'h04;
        run_march(1'b0);
        chk(mem_fail == 2'b01, "R4", "fail only on memory 0", mem_fail, 2'b01);
        chk(rep_valid[0 +: NS] == 2'b01 && rep_row[0 +: AW] == 4'd5, "R5", "single entry row 5",
            {rep_valid[0 +: NS], rep_row[0 +: AW]}, {2'b01, 4'd5});
        chk(mem_repairable[0], "R6", "memory 0 repairable", mem_repairable, 2'b11);
        chk_map(0, 5, D, "R8");
        chk_map(0, 6, 6, "R8");
        chk_map(1, 5, 5, "R8");
    endtask

    task automatic t_two();
        clear_faults();
        stuck[1][9] = 8'h80;
        stuck[1][3] = 8'h01;
        run_march(1'b0);
        chk(rep_valid[NS +: NS] == 2'b11 && rep_row[NS*AW +: AW] == 4'd3 &&
            rep_row[NS*AW + AW +: AW] == 4'd9, "R6", "entries in detection order",
            rep_row[NS*AW +: 2*AW], {4'd9, 4'd3});
        chk(mem_repairable == 2'b11 && mem_fail == 2'b10, "R6", "repairable flags",
            {mem_fail, mem_repairable}, 4'b1011);
        chk_map(1, 9, D + 1, "R8");
        chk_map(1, 3, D, "R8");
    endtask

    task automatic t_over();
        clear_faults();
        stuck[0][1] = 8'h10;
        stuck[0][2] = 8'h10;
        stuck[0][3] = 8'h10;
        run_march(1'b0);
        chk(mem_fail[0] && !mem_repairable[0], "R7", "overflow unrepairable",
            {mem_fail[0], mem_repairable[0]}, 2'b10);
        chk_map(0, 1, 1, "R8");
    endtask

    task automatic t_rerun();
        clear_faults();
        run_march(1'b0);
        chk(mem_fail == '0 && rep_valid == '0, "R9", "log cleared on restart",
            {mem_fail, rep_valid}, 0);
    endtask

    initial begin
        clear_faults();
        for (int m = 0; m < NMEM; m++)
            for (int r = 0; r < D + NS; r++) mem[m][r] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_clean();
        t_single();
        t_two();
        t_over();
        t_rerun();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule